// File: doc/BRIEF.md
# Open-Collector Serial Bus Byte Receiver

This block is the listener side of a three-wire open-collector serial bus (attention, clock, data). It receives exactly one byte from a talker for each start request. After the request it holds the data line low to show that it is busy. It waits until the talker releases the clock. It then releases data to say it is ready for data. If the talker pulls the clock low within a timed window, the byte follows: eight bits, least significant first, each sampled while the clock is released.

If the window runs out with no clock edge, the talker is marking the last byte of a transfer (end-of-information, EOI). The receiver answers with a short data-low pulse, records EOI in its status, and opens the window again. If the window runs out a second time, the talker has stopped responding. The receiver then records a read timeout and lets go of every line. When a byte completes, the receiver pulls data low as an acknowledge and raises a one-cycle strobe with the byte and its EOI flag. After an EOI byte it lets data go again after a set hold time. All timing counts a tick input, and the thresholds are parameters. Both wire inputs pass through a synchronizer and a two-sample debounce.

Top module: `ocbus_byte_rx`

## Requirements
- R1: After reset the data pull enable is 0, `busy_o` is 0, `byte_vld_o` is 0 and `status_o` is 0x00.
- R2: A `start_i` pulse while idle makes the block busy. It pulls data low until the debounced clock line reads high, then releases data. `start_i` has no effect while busy.
- R3: If the clock line goes low within WIN_TICKS ticks after data is released, bit reception starts and no EOI is recorded.
- R4: Eight data bits are taken least significant first. Each bit is the debounced data level seen when the clock line goes high. The bit ends when the clock line goes low.
- R5: When the clock line falls after the eighth bit, the block pulls data low. In the next cycle `byte_vld_o` is high for exactly one cycle, with the byte on `byte_o` and `eoi_o` set if EOI was seen for this byte.
- R6: After a byte without EOI, data stays pulled low while idle until the next start.
- R7: On the first window expiry of a byte, the block sets status bit 6 (0x40) and pulls data low for EOI_TICKS ticks. It then releases data and restarts the window.
- R8: After a byte with EOI, data is released ACK_TICKS ticks after the strobe and the block goes idle.
- R9: A second window expiry in the same byte sets status bit 1 (0x02), releases data, gives no strobe, and returns to idle.
- R10: A clock-line pulse that lasts only one clock cycle does not count as a clock edge.
- R11: Status bits are sticky. Only `status_clr_i` clears them, and a bit being set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time base pulse; one pulse is one tick |
| start_i | input | 1 | Request reception of one byte |
| status_clr_i | input | 1 | Clear the sticky status bits |
| clk_line_i | input | 1 | Raw clock wire level (1 = released) |
| dat_line_i | input | 1 | Raw data wire level (1 = released) |
| dat_pull_o | output | 1 | Pull the data wire low when 1 |
| busy_o | output | 1 | A reception or acknowledge hold is in progress |
| byte_vld_o | output | 1 | One-cycle strobe for a received byte |
| byte_o | output | 8 | Last received byte |
| eoi_o | output | 1 | The strobed byte carried EOI |
| status_o | output | 8 | Sticky status: bit 6 EOI, bit 1 read timeout |

## Verification
The bench plays the talker on a wired-AND bus and goes after the window corner cases. One talker never clocks, which must give an EOI pulse and then a timeout. A design that took the first expiry as a timeout would never report EOI. One that took every expiry as EOI would hang with the block busy. The byte value 0x01 exposes bit-order errors as 0x80. A one-cycle clock glitch inside the window must still lead to the EOI pulse; a receiver without debounce would start clocking bits early and corrupt the byte. The bench also checks that data stays held after a normal byte and is freed after an EOI byte.

// File: rtl/ocbus_rx_pkg.sv
package ocbus_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_RDY,
    S_WINDOW,
    S_EOI_PULL,
    S_BIT_HI,
    S_BIT_LO,
    S_ACK_HOLD
  } rx_state_e;

  localparam int STAT_W       = 8;
  localparam int STAT_EOI_BIT = 6;
  localparam int STAT_TMO_BIT = 1;
endpackage

// File: rtl/ocbus_line_cond.sv
module ocbus_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter bit RST_LVL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl_q;
  logic                   lvl_d;
  logic                   newest;

  assign newest = sync_q[SYNC_STAGES-1];

  // accept a level only when two consecutive synchronized reads agree
  always_comb begin
    lvl_d = lvl_q;
    if (newest == prev_q) lvl_d = newest;
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RST_LVL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= RST_LVL;
        else        sync_q <= raw_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_LVL;
      lvl_q  <= RST_LVL;
    end else begin
      prev_q <= newest;
      lvl_q  <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/ocbus_tick_timer.sv
module ocbus_tick_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired_o = (cnt_q >= limit_i);
  assign cnt_en    = restart_i | (tick_i & ~expired_o);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocbus_byte_rx.sv
module ocbus_byte_rx
  import ocbus_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WIN_TICKS   = 256,
  parameter int EOI_TICKS   = 40,
  parameter int ACK_TICKS   = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              status_clr_i,
  input  logic              clk_line_i,
  input  logic              dat_line_i,
  output logic              dat_pull_o,
  output logic              busy_o,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              eoi_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int MAX_T = (WIN_TICKS > EOI_TICKS) ?
                         ((WIN_TICKS > ACK_TICKS) ? WIN_TICKS : ACK_TICKS) :
                         ((EOI_TICKS > ACK_TICKS) ? EOI_TICKS : ACK_TICKS);
  localparam int TCW   = $clog2(MAX_T + 1);
  localparam int BCW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TCW-1:0] LIM_WIN = TCW'(WIN_TICKS);
  localparam logic [TCW-1:0] LIM_EOI = TCW'(EOI_TICKS);
  localparam logic [TCW-1:0] LIM_ACK = TCW'(ACK_TICKS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic              eoi_q, eoi_d;
  logic              hold_q, hold_d;
  logic              vld_q, vld_d;
  logic [STAT_W-1:0] stat_q, stat_d;

  logic              clk_lvl, dat_lvl;
  logic              tmr_restart, tmr_expired;
  logic [TCW-1:0]    tmr_limit;

  ocbus_line_cond #(.SYNC_STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_clk_cond (
    .clk(clk), .rst_n(rst_n), .raw_i(clk_line_i), .lvl_o(clk_lvl)
  );

  ocbus_line_cond #(.SYNC_STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_dat_cond (
    .clk(clk), .rst_n(rst_n), .raw_i(dat_line_i), .lvl_o(dat_lvl)
  );

  // one shared timer, restarted on every state change
  always_comb begin
    case (state_q)
      S_EOI_PULL: tmr_limit = LIM_EOI;
      S_ACK_HOLD: tmr_limit = LIM_ACK;
      default:    tmr_limit = LIM_WIN;
    endcase
  end

  assign tmr_restart = (state_d != state_q);

  ocbus_tick_timer #(.CW(TCW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(tmr_restart), .tick_i(tick_i),
    .limit_i(tmr_limit), .expired_o(tmr_expired)
  );

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    eoi_d   = eoi_q;
    hold_d  = hold_q;
    vld_d   = 1'b0;
    stat_d  = status_clr_i ? '0 : stat_q;

    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_WAIT_RDY;
          eoi_d   = 1'b0;
          bit_d   = '0;
        end
      end
      S_WAIT_RDY: begin
        if (clk_lvl) state_d = S_WINDOW;
      end
      S_WINDOW: begin
        if (!clk_lvl) begin
          state_d = S_BIT_HI;
        end else if (tmr_expired) begin
          if (eoi_q) begin
            stat_d[STAT_TMO_BIT] = 1'b1;
            hold_d  = 1'b0;
            state_d = S_IDLE;
          end else begin
            stat_d[STAT_EOI_BIT] = 1'b1;
            eoi_d   = 1'b1;
            state_d = S_EOI_PULL;
          end
        end
      end
      S_EOI_PULL: begin
        if (tmr_expired) state_d = S_WINDOW;
      end
      S_BIT_HI: begin
        if (clk_lvl) begin
          sh_d    = {dat_lvl, sh_q[DATA_W-1:1]};
          state_d = S_BIT_LO;
        end
      end
      S_BIT_LO: begin
        if (!clk_lvl) begin
          if (bit_q == LAST_BIT) begin
            vld_d   = 1'b1;
            hold_d  = ~eoi_q;
            state_d = eoi_q ? S_ACK_HOLD : S_IDLE;
          end else begin
            bit_d   = bit_q + 1'b1;
            state_d = S_BIT_HI;
          end
        end
      end
      S_ACK_HOLD: begin
        if (tmr_expired) begin
          hold_d  = 1'b0;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      eoi_q   <= 1'b0;
      hold_q  <= 1'b0;
      vld_q   <= 1'b0;
      stat_q  <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      eoi_q   <= eoi_d;
      hold_q  <= hold_d;
      vld_q   <= vld_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    case (state_q)
      S_IDLE:     dat_pull_o = hold_q;
      S_WAIT_RDY,
      S_EOI_PULL,
      S_ACK_HOLD: dat_pull_o = 1'b1;
      default:    dat_pull_o = 1'b0;
    endcase
  end

  assign busy_o     = (state_q != S_IDLE);
  assign byte_vld_o = vld_q;
  assign byte_o     = sh_q;
  assign eoi_o      = vld_q & eoi_q;
  assign status_o   = stat_q;
endmodule

// File: rtl/ocbus_byte_rx_chk.sv
module ocbus_byte_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       status_clr_i,
  input logic       dat_pull_o,
  input logic       busy_o,
  input logic       byte_vld_o,
  input logic [7:0] status_o
);
  // R2: leaving idle only follows a start request
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R5: the strobe lasts a single cycle
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  // R5: the byte is acknowledged by a held data line while strobed
  p_strobe_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> dat_pull_o);

  // R9: a timeout leaves the block idle with the data line free
  p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> (!busy_o && !dat_pull_o && !byte_vld_o));

  // R11: status bits only drop on a clear request
  p_eoi_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[6]) |-> $past(status_clr_i));

  p_tmo_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[1]) |-> $past(status_clr_i));
endmodule

bind ocbus_byte_rx ocbus_byte_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_clr_i(status_clr_i),
  .dat_pull_o(dat_pull_o), .busy_o(busy_o), .byte_vld_o(byte_vld_o),
  .status_o(status_o)
);

// File: tb/ocbus_byte_rx_tb_top.sv
module ocbus_byte_rx_tb_top;
  localparam int WIN = 16;
  localparam int EOIT = 4;
  localparam int ACKT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start = 1'b0;
  logic sclr = 1'b0;
  logic tp_clk = 1'b1;   // talker pulls clock low
  logic tp_dat = 1'b0;   // talker pulls data low
  logic dat_pull, busy, vld, eoi;
  logic [7:0] rbyte, status;
  logic clk_line, dat_line;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  logic [7:0] cap_byte = 8'h00;
  logic cap_eoi = 1'b0;
  bit finished = 1'b0;
  logic [1:0] tdiv = 2'd0;

  always #2 clk = ~clk;   // 250 MHz

  assign clk_line = ~tp_clk;
  assign dat_line = ~(tp_dat | dat_pull);

  ocbus_byte_rx #(.WIN_TICKS(WIN), .EOI_TICKS(EOIT), .ACK_TICKS(ACKT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start),
    .status_clr_i(sclr), .clk_line_i(clk_line), .dat_line_i(dat_line),
    .dat_pull_o(dat_pull), .busy_o(busy), .byte_vld_o(vld), .byte_o(rbyte),
    .eoi_o(eoi), .status_o(status)
  );

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  always @(negedge clk) begin
    if (vld) begin
      strobes  = strobes + 1;
      cap_byte = rbyte;
      cap_eoi  = eoi;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // talker releases clock, waits for listener to release data
  task automatic talker_ready(input string req);
    int n;
    n = 0;
    tp_clk = 1'b0;
    while (dat_line !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    check(dat_line === 1'b1, req, dat_line, 1);
  endtask

  task automatic send_bits(input logic [7:0] b, input bit poke_start);
    tp_clk = 1'b1;
    wait_clks(10);
    for (int i = 0; i < 8; i++) begin
      tp_dat = ~b[i];
      wait_clks(2);
      tp_clk = 1'b0;
      wait_clks(10);
      tp_clk = 1'b1;
      if (poke_start && i == 3) pulse_start();
      wait_clks(10);
    end
    tp_dat = 1'b0;
  endtask

  task automatic wait_pull(input logic lvl, output int waited);
    waited = 0;
    while (dat_pull !== lvl && waited < 400) begin @(negedge clk); waited++; end
  endtask

  task automatic t_reset();
    check(dat_pull === 1'b0, "R1 pull", dat_pull, 0);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(vld === 1'b0, "R1 vld", vld, 0);
    check(status === 8'h00, "R1 status", status, 0);
  endtask

  task automatic t_plain(input logic [7:0] b, input bit poke);
    int s0;
    s0 = strobes;
    tp_clk = 1'b1;
    pulse_start();
    wait_clks(6);
    check(busy === 1'b1 && dat_pull === 1'b1, "R2 busy hold", {busy, dat_pull}, 3);
    talker_ready("R2 ready");
    send_bits(b, poke);
    wait_clks(8);
    check(strobes == s0 + 1, "R5 strobe count", strobes - s0, 1);
    check(cap_byte === b, "R4 byte", cap_byte, b);
    check(cap_eoi === 1'b0, "R3 no eoi", cap_eoi, 0);
    check(status[6] === 1'b0, "R3 status", status, 0);
    wait_clks(50);
    check(dat_pull === 1'b1 && busy === 1'b0, "R6 idle hold", {busy, dat_pull}, 1);
  endtask

  task automatic t_eoi(input logic [7:0] b, input bit glitch);
    int w;
    int s0;
    s0 = strobes;
    tp_clk = 1'b1;
    pulse_start();
    wait_clks(6);
    talker_ready("R2 ready eoi");
    if (glitch) begin
      tp_clk = 1'b1;
      @(negedge clk);
      tp_clk = 1'b0;
    end
    wait_pull(1'b1, w);
    check(dat_pull === 1'b1, glitch ? "R10 glitch ignored" : "R7 eoi pulse", dat_pull, 1);
    check(status[6] === 1'b1, "R7 status eoi", status, 8'h40);
    wait_pull(1'b0, w);
    check(w >= 12 && w <= 20, "R7 pulse length", w, 4 * EOIT);
    send_bits(b, 1'b0);
    wait_clks(8);
    check(strobes == s0 + 1 && cap_eoi === 1'b1, "R7 eoi flag", {strobes - s0, cap_eoi}, 3);
    check(cap_byte === b, glitch ? "R10 byte" : "R4 eoi byte", cap_byte, b);
    check(dat_pull === 1'b1, "R8 ack held", dat_pull, 1);
    wait_clks(40);
    check(dat_pull === 1'b0 && busy === 1'b0, "R8 release", {busy, dat_pull}, 0);
  endtask

  task automatic t_clear();
    sclr = 1'b1;
    @(negedge clk);
    sclr = 1'b0;
    @(negedge clk);
    check(status === 8'h00, "R11 clear", status, 0);
  endtask

  task automatic t_timeout();
    int n;
    int s0;
    s0 = strobes;
    tp_clk = 1'b1;
    pulse_start();
    wait_clks(6);
    talker_ready("R2 ready tmo");
    n = 0;
    while (busy !== 1'b0 && n < 600) begin @(negedge clk); n++; end
    check(busy === 1'b0, "R9 idle", busy, 0);
    check(status === 8'h42, "R9 status", status, 8'h42);
    check(strobes == s0, "R9 no strobe", strobes - s0, 0);
    check(dat_pull === 1'b0, "R9 release", dat_pull, 0);
    wait_clks(20);
    check(status === 8'h42, "R11 sticky", status, 8'h42);
  endtask

  initial begin
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(4);
    t_reset();
    t_plain(8'hA5, 1'b0);
    t_plain(8'h01, 1'b1);
    t_eoi(8'h5A, 1'b0);
    check(status === 8'h40, "R11 held", status, 8'h40);
    t_clear();
    t_eoi(8'h96, 1'b1);
    t_clear();
    t_timeout();
    t_clear();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule